// File: doc/BRIEF.md
# Narrow Pulse Event Counter

This block counts short, asynchronous input pulses whose width can be anywhere from about 1 ns to 3 ns. They arrive at a low rate, with more than 70 ns between rising edges. A pulse that narrow would slip between samples of the system clock. Instead, each rising edge of the pulse line clocks a one-bit toggle register, so every pulse becomes a lasting change of level.

That level is carried into the system clock domain through a chain of synchronizer flip-flops. A change detector compares the synchronized level with its value one cycle earlier. Any difference, rising or falling, becomes a one-cycle count event. A registered saturating counter counts these events, so the total can be read directly in the system domain. The counter stops at its all-ones value and does not wrap.

An active-low reset clears the toggle register, the synchronizer chain and the counter. The system clock must be fast enough that three clock cycles fit inside the minimum pulse spacing.

Top module: `narrow_pulse_counter`

## Requirements
- R1: Every rising edge on `pulse_in` adds exactly one to `count_o`, for any pulse width from 1 ns to 3 ns, as long as successive rising edges are more than 70 ns apart.
- R2: The increment caused by a pulse is visible on `count_o` no later than the fourth rising `clk` edge after the pulse's rising edge, with the default two-stage synchronizer.
- R3: `count_o` saturates at the all-ones value 2^CNT_W-1 (4095 with the default CNT_W = 12) and stays there as further pulses arrive.
- R4: While `rst_n` is sampled low on a rising `clk` edge, `count_o` reads zero after that edge.
- R5: Pulses that arrive while `rst_n` is low are not counted, and releasing the reset produces no count: `count_o` stays zero until the first pulse after release.
- R6: Outside reset, `count_o` never decreases and changes by at most one per clock cycle.
- R7: A deeper synchronizer (parameter SYNC_STAGES, at least 2) changes only the latency, not the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pulse_in | input | 1 | Raw asynchronous pulse line; its rising edge clocks the toggle register |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset: clears the toggle register asynchronously and the system-domain state synchronously |
| count_o | output | CNT_W (12) | Registered saturating pulse count in the `clk` domain |

## Verification
The bench builds two copies side by side, driven by the same pulse train. The first uses the defaults, CNT_W = 12 and SYNC_STAGES = 2. It receives more than 4095 pulses of random width and random spacing above 70 ns, so every count value up to and into saturation is compared against an arithmetic model. The second uses CNT_W = 3 and SYNC_STAGES = 3. It reaches saturation after only seven pulses, and it shows that the extra synchronizer stage leaves the count unchanged. A short fixed-latency window after selected pulses tests the cycle bound. Pulses fired during reset test that reset leaves no stray event behind.

// File: rtl/pec_pkg.sv
package pec_pkg;
  // Smallest synchronizer depth accepted for the level crossing.
  localparam int unsigned PEC_MIN_SYNC = 2;
endpackage

// File: rtl/pec_toggle_capture.sv
// Pulse-domain capture: one inversion per rising edge of the raw line.
module pec_toggle_capture (
  input  logic pulse_i,
  input  logic rst_n,
  output logic tog_o
);
  // The pulse line is the only clock here, so the clear must be asynchronous.
  always_ff @(posedge pulse_i or negedge rst_n) begin
    if (!rst_n) tog_o <= 1'b0;
    else        tog_o <= ~tog_o;
  end
endmodule

// File: rtl/pec_level_sync.sv
// Multi-flop synchronizer for the toggle level.
module pec_level_sync
  import pec_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  if (STAGES < PEC_MIN_SYNC) begin : g_depth_bad
    $error("pec_level_sync: STAGES below minimum");
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

  // R7: the output only follows a level that has already been held one stage earlier.
  p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_o != $past(q_o) |-> q_o == $past(chain_q[STAGES-2]));
endmodule

// File: rtl/pec_change_detect.sv
// Turns any change of the synchronized level into a one-cycle event.
module pec_change_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign evt_o = lvl_i ^ prev_q;

  // R1: one pulse yields one event, never a two-cycle event.
  p_single_evt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);
endmodule

// File: rtl/pec_sat_counter.sv
// Registered saturating event counter.
module pec_sat_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  // R3: once at the top, the count stays there.
  p_hold_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o == CNT_MAX |=> cnt_o == CNT_MAX);
  // R1: an event below the top always moves the count.
  p_event_counts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && cnt_o != CNT_MAX) |=> cnt_o != $past(cnt_o));
  // R6: any change is a single upward step.
  p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o != $past(cnt_o) |-> cnt_o == $past(cnt_o) + 1'b1);
  // R4: a sampled reset leaves zero behind.
  p_reset_zero_r4: assert property (@(posedge clk)
    !rst_n |=> cnt_o == '0);
endmodule

// File: rtl/narrow_pulse_counter.sv
module narrow_pulse_counter #(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             pulse_in,
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count_o
);
  logic tog;
  logic tog_sync;
  logic evt;

  pec_toggle_capture u_cap (
    .pulse_i (pulse_in),
    .rst_n   (rst_n),
    .tog_o   (tog)
  );

  pec_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (tog),
    .q_o   (tog_sync)
  );

  pec_change_detect u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (tog_sync),
    .evt_o (evt)
  );

  pec_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (evt),
    .cnt_o (count_o)
  );

  // R5: no count event can appear while reset holds the path.
  p_quiet_reset_r5: assert property (@(posedge clk)
    !rst_n |=> !evt);
endmodule

// File: tb/sim_narrow_pulse_counter.sv
`timescale 1ns/1ps
module sim_narrow_pulse_counter;
  localparam int W0 = 12;
  localparam int W1 = 3;
  localparam int MAX0 = (1 << W0) - 1;
  localparam int MAX1 = (1 << W1) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse = 1'b0;
  logic [W0-1:0] cnt0;
  logic [W1-1:0] cnt1;

  int total = 0;
  int bad = 0;
  int sent = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  narrow_pulse_counter #(.CNT_W(W0), .SYNC_STAGES(2)) u0 (
    .pulse_in(pulse), .clk(clk), .rst_n(rst_n), .count_o(cnt0));
  narrow_pulse_counter #(.CNT_W(W1), .SYNC_STAGES(3)) u1 (
    .pulse_in(pulse), .clk(clk), .rst_n(rst_n), .count_o(cnt1));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (pulses=%0d)", req, act, exp, sent);
    end
  endtask

  function automatic int model(input int n, input int mx);
    return (n > mx) ? mx : n;
  endfunction

  task automatic fire();
    real w;
    w = 1.0 + real'($urandom_range(0, 200)) / 100.0;
    pulse = 1'b1;
    #(w);
    pulse = 1'b0;
  endtask

  task automatic fire_spaced();
    real w;
    int gap;
    w = 1.0 + real'($urandom_range(0, 200)) / 100.0;
    gap = $urandom_range(71, 110);
    pulse = 1'b1;
    #(w);
    pulse = 1'b0;
    #(real'(gap) - w);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R4 reset u0", cnt0, 0);
    check("R4 reset u1", cnt1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 release u0", cnt0, 0);

    // R2: the count must be visible within four clock edges.
    for (int k = 0; k < 6; k++) begin
      #($urandom_range(0, 3));
      fire();
      sent++;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R2 latency u0", cnt0, model(sent, MAX0));
      #(80);
      @(negedge clk);
    end

    // R1, R3, R7: random widths and spacings, on into saturation.
    while (sent < MAX0 + 60) begin
      fire_spaced();
      sent++;
      check("R1 count u0", cnt0, model(sent, MAX0));
      check("R7 count u1", cnt1, model(sent, MAX1));
      if (sent >= MAX0) check("R3 saturate u0", cnt0, MAX0);
      if (sent >= MAX1) check("R3 saturate u1", cnt1, MAX1);
    end

    // R4 and R5: a mid-run reset, with pulses while it is held.
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 mid-run u0", cnt0, 0);
    check("R4 mid-run u1", cnt1, 0);
    for (int k = 0; k < 3; k++) begin
      fire();
      #(75);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R5 ignored u0", cnt0, 0);
    check("R5 ignored u1", cnt1, 0);

    sent = 0;
    for (int k = 0; k < 9; k++) begin
      fire_spaced();
      sent++;
      check("R1 after reset u0", cnt0, model(sent, MAX0));
      check("R3 after reset u1", cnt1, model(sent, MAX1));
    end

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule